// File: doc/BRIEF.md
# Multi-Field Video Scan Address Generator

This block produces the row and column addresses used to scan pixels out of, or into, a frame store that holds 4096 x 4096 words of 32 bits. It keeps a table of up to eight fields. Each field has its own 12-bit start row and 12-bit start column. A separate order list of one to eight entries names which field each successive frame shows. The list is walked over and over without further commands, so interleaved or stereo displays refresh on their own. Pixels along a line are spread over four memory modules in turn, so the per-module column address steps once for every four pixels.

The block has no timing generator of its own. A frame-start strobe loads the next field from the order list. A line-start strobe moves to the next row. A pixel strobe advances along the line. A small command port writes field starts, edits the order list and its length, and requests a buffer swap. Order edits and swaps wait as pending until the next frame-start strobe, so the picture never tears in the middle of a frame. The swap flips the top row bit, which selects between two 4096 x 2048 halves of the store.

Top module: `scan_addr_gen`

## Requirements
- R1: After a synchronous reset, row_addr, col_addr, mod_sel, field_id and buf_sel are all zero. The order list holds entry k = field k with a length of one, and no order edit or swap is pending.
- R2: Command op 0 writes field cmd_idx with start row cmd_data[23:12] and start column cmd_data[11:0]. On frame_start the outputs load the start of the field chosen by the order list: col_addr = start column, mod_sel = 0, field_id = that field, and row_addr = start row with bit 11 inverted when buf_sel is 1.
- R3: Successive frame_start strobes take fields from order entries 0, 1, ..., L-1, then wrap to entry 0, where L is the programmed length.
- R4: Command op 1 sets order entry cmd_idx to field cmd_data[2:0]. Command op 2 sets the length to cmd_data[2:0]+1. Both edits are held pending and take effect at the next frame_start, and that frame uses entry 0 of the new list. A command in the same cycle as a frame_start counts for the following frame.
- R5: Command op 3 requests a buffer swap. At the next frame_start buf_sel toggles once, however many swaps were requested, and the new value applies to the frame being loaded.
- R6: On line_start without frame_start, col_addr reloads the current field's start column and mod_sel becomes 0. The first line_start after a frame_start, or after reset, leaves row_addr unchanged. Each later one increments row_addr modulo 4096.
- R7: On pix_en alone, mod_sel steps 0, 1, 2, 3, 0. col_addr increments only when mod_sel goes from 3 back to 0.
- R8: frame_start takes priority over line_start, and line_start takes priority over pix_en. In a cycle with no strobe, every output holds.
- R9: Commands never change the outputs directly. A field start written during a frame affects neither the running frame nor its line reloads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Frame boundary strobe |
| line_start | input | 1 | Line boundary strobe |
| pix_en | input | 1 | Pixel advance strobe |
| cmd_valid | input | 1 | Command present this cycle |
| cmd_op | input | 2 | 0 field start, 1 order entry, 2 order length, 3 swap |
| cmd_idx | input | 3 | Field or order entry index |
| cmd_data | input | 24 | Command payload |
| row_addr | output | 12 | Current scan row address |
| col_addr | output | 12 | Current per-module column address |
| mod_sel | output | 2 | Memory module of the current pixel |
| field_id | output | 3 | Field being scanned |
| buf_sel | output | 1 | Active display buffer |

## Verification
The checker enforces the following on every cycle:
- the strobe priority;
- the module step and the column carry after each pixel;
- the row step or hold after a line start, which depends on whether it is the first line of the frame;
- that every output holds in idle cycles, including cycles where only a command arrives.

Other behaviour depends on state kept across many frames and can only be shown by the bench scenarios:
- which field each frame picks as the order list wraps;
- that an order edit waits for the next frame and then restarts at entry 0;
- that several swap requests before one frame give a single toggle;
- the row wrap from 4095 to 0.

// File: rtl/scan_addr_pkg.sv
package scan_addr_pkg;
  typedef enum logic [1:0] {
    OP_FIELD = 2'd0,
    OP_ORDER = 2'd1,
    OP_LEN   = 2'd2,
    OP_SWAP  = 2'd3
  } scan_op_e;
endpackage

// File: rtl/scan_field_table.sv
module scan_field_table #(
  parameter int NFIELD = 8,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 12,
  localparam int FID_W = $clog2(NFIELD),
  localparam int ENT_W = ROW_W + COL_W
) (
  input  logic             clk,
  input  logic             we,
  input  logic [FID_W-1:0] waddr,
  input  logic [ENT_W-1:0] wdata,
  input  logic [FID_W-1:0] raddr,
  output logic [ROW_W-1:0] start_row,
  output logic [COL_W-1:0] start_col
);
  logic [ENT_W-1:0] mem [NFIELD];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign start_row = mem[raddr][ENT_W-1:COL_W];
  assign start_col = mem[raddr][COL_W-1:0];
endmodule

// File: rtl/scan_order_seq.sv
module scan_order_seq #(
  parameter int NFIELD = 8,
  localparam int FID_W = $clog2(NFIELD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             wr_entry,
  input  logic             wr_len,
  input  logic             req_swap,
  input  logic [FID_W-1:0] idx,
  input  logic [FID_W-1:0] val,
  output logic [FID_W-1:0] sel_fid,
  output logic             sel_buf
);
  logic [FID_W-1:0] act_ord [NFIELD];
  logic [FID_W-1:0] sh_ord  [NFIELD];
  logic [FID_W-1:0] act_last, sh_last, pos;
  logic             ord_pend, swap_pend, buf_q;
  logic [FID_W-1:0] next_pos;

  always_comb begin
    if (ord_pend) begin
      sel_fid  = sh_ord[0];
      next_pos = (sh_last == '0) ? '0 : FID_W'(1);
    end else begin
      sel_fid  = act_ord[pos];
      next_pos = (pos == act_last) ? '0 : pos + FID_W'(1);
    end
    sel_buf = buf_q ^ swap_pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int e = 0; e < NFIELD; e++) begin
        act_ord[e] <= FID_W'(e);
        sh_ord[e]  <= FID_W'(e);
      end
      act_last  <= '0;
      sh_last   <= '0;
      pos       <= '0;
      ord_pend  <= 1'b0;
      swap_pend <= 1'b0;
      buf_q     <= 1'b0;
    end else begin
      if (frame_start) begin
        pos       <= next_pos;
        buf_q     <= sel_buf;
        swap_pend <= 1'b0;
        if (ord_pend) begin
          for (int e = 0; e < NFIELD; e++) act_ord[e] <= sh_ord[e];
          act_last <= sh_last;
          ord_pend <= 1'b0;
        end
      end
      if (wr_entry) begin
        sh_ord[idx] <= val;
        ord_pend    <= 1'b1;
      end
      if (wr_len) begin
        sh_last  <= val;
        ord_pend <= 1'b1;
      end
      if (req_swap) swap_pend <= 1'b1;
    end
  end
endmodule

// File: rtl/scan_addr_ctr.sv
module scan_addr_ctr #(
  parameter int NFIELD = 8,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 12,
  parameter int NMOD   = 4,
  localparam int FID_W = $clog2(NFIELD),
  localparam int MOD_W = $clog2(NMOD)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             line_start,
  input  logic             pix_en,
  input  logic [ROW_W-1:0] ld_row,
  input  logic [COL_W-1:0] ld_col,
  input  logic [FID_W-1:0] ld_fid,
  input  logic             ld_buf,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic [MOD_W-1:0] mod_sel,
  output logic [FID_W-1:0] field_id,
  output logic             buf_sel,
  output logic             first_line
);
  logic [COL_W-1:0] col_base;

  always_ff @(posedge clk) begin
    if (rst) begin
      row_addr   <= '0;
      col_addr   <= '0;
      col_base   <= '0;
      mod_sel    <= '0;
      field_id   <= '0;
      buf_sel    <= 1'b0;
      first_line <= 1'b1;
    end else if (frame_start) begin
      row_addr   <= {ld_row[ROW_W-1] ^ ld_buf, ld_row[ROW_W-2:0]};
      col_addr   <= ld_col;
      col_base   <= ld_col;
      mod_sel    <= '0;
      field_id   <= ld_fid;
      buf_sel    <= ld_buf;
      first_line <= 1'b1;
    end else if (line_start) begin
      if (!first_line) row_addr <= row_addr + ROW_W'(1);
      first_line <= 1'b0;
      col_addr   <= col_base;
      mod_sel    <= '0;
    end else if (pix_en) begin
      if (mod_sel == MOD_W'(NMOD - 1)) col_addr <= col_addr + COL_W'(1);
      mod_sel <= mod_sel + MOD_W'(1);
    end
  end
endmodule

// File: rtl/scan_addr_gen.sv
module scan_addr_gen #(
  parameter int NFIELD = 8,
  parameter int ROW_W  = 12,
  parameter int COL_W  = 12,
  parameter int NMOD   = 4,
  localparam int FID_W = $clog2(NFIELD),
  localparam int MOD_W = $clog2(NMOD),
  localparam int DAT_W = ROW_W + COL_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             line_start,
  input  logic             pix_en,
  input  logic             cmd_valid,
  input  logic [1:0]       cmd_op,
  input  logic [FID_W-1:0] cmd_idx,
  input  logic [DAT_W-1:0] cmd_data,
  output logic [ROW_W-1:0] row_addr,
  output logic [COL_W-1:0] col_addr,
  output logic [MOD_W-1:0] mod_sel,
  output logic [FID_W-1:0] field_id,
  output logic             buf_sel
);
  import scan_addr_pkg::*;

  logic             wr_field, wr_entry, wr_len, req_swap;
  logic [FID_W-1:0] sel_fid;
  logic             sel_buf;
  logic [ROW_W-1:0] st_row;
  logic [COL_W-1:0] st_col;
  logic             first_line;

  assign wr_field = cmd_valid && (scan_op_e'(cmd_op) == OP_FIELD);
  assign wr_entry = cmd_valid && (scan_op_e'(cmd_op) == OP_ORDER);
  assign wr_len   = cmd_valid && (scan_op_e'(cmd_op) == OP_LEN);
  assign req_swap = cmd_valid && (scan_op_e'(cmd_op) == OP_SWAP);

  scan_field_table #(.NFIELD(NFIELD), .ROW_W(ROW_W), .COL_W(COL_W)) i_tab (
    .clk(clk), .we(wr_field), .waddr(cmd_idx), .wdata(cmd_data),
    .raddr(sel_fid), .start_row(st_row), .start_col(st_col)
  );

  scan_order_seq #(.NFIELD(NFIELD)) i_seq (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .wr_entry(wr_entry), .wr_len(wr_len), .req_swap(req_swap),
    .idx(cmd_idx), .val(cmd_data[FID_W-1:0]),
    .sel_fid(sel_fid), .sel_buf(sel_buf)
  );

  scan_addr_ctr #(.NFIELD(NFIELD), .ROW_W(ROW_W), .COL_W(COL_W), .NMOD(NMOD)) i_ctr (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .pix_en(pix_en), .ld_row(st_row), .ld_col(st_col), .ld_fid(sel_fid),
    .ld_buf(sel_buf), .row_addr(row_addr), .col_addr(col_addr),
    .mod_sel(mod_sel), .field_id(field_id), .buf_sel(buf_sel),
    .first_line(first_line)
  );
endmodule

// File: rtl/scan_addr_gen_chk.sv
module scan_addr_gen_chk #(
  parameter int ROW_W = 12,
  parameter int COL_W = 12,
  parameter int MOD_W = 2,
  parameter int FID_W = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             line_start,
  input logic             pix_en,
  input logic [ROW_W-1:0] row_addr,
  input logic [COL_W-1:0] col_addr,
  input logic [MOD_W-1:0] mod_sel,
  input logic [FID_W-1:0] field_id,
  input logic             buf_sel,
  input logic             first_line
);
  // R8 and R9: with no strobe, nothing moves, even when a command arrives
  a_r8_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !line_start && !pix_en) |=>
      ($stable(row_addr) && $stable(col_addr) && $stable(mod_sel) &&
       $stable(field_id) && $stable(buf_sel)));

  a_r7_mod_step: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !frame_start && !line_start) |=>
      (mod_sel == MOD_W'($past(mod_sel) + MOD_W'(1))));

  a_r7_col_carry: assert property (@(posedge clk) disable iff (rst)
    (pix_en && !frame_start && !line_start) |=>
      (col_addr == (($past(mod_sel) == '1) ? COL_W'($past(col_addr) + COL_W'(1))
                                           : $past(col_addr))));

  a_r6_line_mod: assert property (@(posedge clk) disable iff (rst)
    (line_start && !frame_start) |=>
      (mod_sel == '0 && $stable(field_id) && $stable(buf_sel)));

  a_r6_row_step: assert property (@(posedge clk) disable iff (rst)
    (line_start && !frame_start && !first_line) |=>
      (row_addr == ROW_W'($past(row_addr) + ROW_W'(1))));

  a_r6_row_hold: assert property (@(posedge clk) disable iff (rst)
    (line_start && !frame_start && first_line) |=> $stable(row_addr));

  a_r2_frame_mod: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> (mod_sel == '0));
endmodule

bind scan_addr_gen scan_addr_gen_chk #(
  .ROW_W(ROW_W), .COL_W(COL_W), .MOD_W(MOD_W), .FID_W(FID_W)
) i_chk (
  .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
  .pix_en(pix_en), .row_addr(row_addr), .col_addr(col_addr),
  .mod_sel(mod_sel), .field_id(field_id), .buf_sel(buf_sel),
  .first_line(first_line)
);

// File: tb/test_scan_addr_gen.sv
`timescale 1ns/1ps
module test_scan_addr_gen;
  logic        clk = 1'b0;
  logic        rst;
  logic        frame_start, line_start, pix_en, cmd_valid;
  logic [1:0]  cmd_op;
  logic [2:0]  cmd_idx;
  logic [23:0] cmd_data;
  logic [11:0] row_addr, col_addr;
  logic [1:0]  mod_sel;
  logic [2:0]  field_id;
  logic        buf_sel;

  int n_vec = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  // expected-state model built from the requirements
  logic [11:0] m_frow [8];
  logic [11:0] m_fcol [8];
  logic [2:0]  m_act [8];
  logic [2:0]  m_sh  [8];
  logic [2:0]  m_alast, m_slast, m_pos;
  bit          m_pend, m_swp, m_buf, m_first;
  logic [11:0] e_row, e_col, m_cbase;
  logic [1:0]  e_mod;
  logic [2:0]  e_fid;
  bit          e_buf;

  always #4 clk = ~clk;

  scan_addr_gen i_scan_addr_gen (
    .clk(clk), .rst(rst), .frame_start(frame_start), .line_start(line_start),
    .pix_en(pix_en), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .cmd_data(cmd_data), .row_addr(row_addr), .col_addr(col_addr),
    .mod_sel(mod_sel), .field_id(field_id), .buf_sel(buf_sel)
  );

  task automatic model_reset();
    for (int k = 0; k < 8; k++) begin
      m_act[k] = 3'(k); m_sh[k] = 3'(k); m_frow[k] = '0; m_fcol[k] = '0;
    end
    m_alast = 0; m_slast = 0; m_pos = 0; m_pend = 0; m_swp = 0; m_buf = 0;
    m_first = 1; e_row = 0; e_col = 0; m_cbase = 0; e_mod = 0; e_fid = 0; e_buf = 0;
  endtask

  task automatic model_step(bit f, bit l, bit p, bit cv, logic [1:0] op,
                            logic [2:0] ix, logic [23:0] d);
    logic [2:0] fid;
    if (f) begin
      if (m_pend) begin
        for (int k = 0; k < 8; k++) m_act[k] = m_sh[k];
        m_alast = m_slast; fid = m_sh[0];
        m_pos = (m_slast == 0) ? 3'd0 : 3'd1; m_pend = 0;
      end else begin
        fid = m_act[m_pos];
        m_pos = (m_pos == m_alast) ? 3'd0 : m_pos + 3'd1;
      end
      m_buf = m_buf ^ m_swp; m_swp = 0;
      e_row = {m_frow[fid][11] ^ m_buf, m_frow[fid][10:0]};
      e_col = m_fcol[fid]; m_cbase = m_fcol[fid];
      e_mod = 0; e_fid = fid; e_buf = m_buf; m_first = 1;
    end else if (l) begin
      if (m_first) m_first = 0; else e_row = e_row + 12'd1;
      e_col = m_cbase; e_mod = 0;
    end else if (p) begin
      if (e_mod == 2'd3) e_col = e_col + 12'd1;
      e_mod = e_mod + 2'd1;
    end
    if (cv) begin
      case (op)
        2'd0: begin m_frow[ix] = d[23:12]; m_fcol[ix] = d[11:0]; end
        2'd1: begin m_sh[ix] = d[2:0]; m_pend = 1; end
        2'd2: begin m_slast = d[2:0]; m_pend = 1; end
        default: m_swp = 1;
      endcase
    end
  endtask

  task automatic check(string tag);
    n_vec++;
    if (row_addr !== e_row || col_addr !== e_col || mod_sel !== e_mod ||
        field_id !== e_fid || buf_sel !== e_buf) begin
      n_bad++;
      $display("FAIL %s: got row=%0d col=%0d mod=%0d fid=%0d buf=%0d exp row=%0d col=%0d mod=%0d fid=%0d buf=%0d",
               tag, row_addr, col_addr, mod_sel, field_id, buf_sel,
               e_row, e_col, e_mod, e_fid, e_buf);
    end
  endtask

  // drive at negedge, sample at the following negedge (outputs are registered)
  task automatic step(bit f, bit l, bit p, bit cv, logic [1:0] op,
                      logic [2:0] ix, logic [23:0] d, string tag);
    frame_start = f; line_start = l; pix_en = p;
    cmd_valid = cv; cmd_op = op; cmd_idx = ix; cmd_data = d;
    model_step(f, l, p, cv, op, ix, d);
    @(posedge clk);
    @(negedge clk);
    check(tag);
  endtask

  task automatic cmd(logic [1:0] op, logic [2:0] ix, logic [23:0] d, string tag);
    step(0, 0, 0, 1, op, ix, d, tag);
  endtask

  initial begin
    #(8 * 150000);
    n_bad++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    int unsigned seed;
    int unsigned r;
    seed = 32'd1234;
    r = $urandom(seed);
    rst = 1; frame_start = 0; line_start = 0; pix_en = 0;
    cmd_valid = 0; cmd_op = 0; cmd_idx = 0; cmd_data = 0;
    model_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 0;
    check("R1 reset state");

    // R2: fill the field table; field 5 sits at the last row
    for (int k = 0; k < 8; k++)
      cmd(2'd0, 3'(k), (k == 5) ? {12'd4095, 12'd40} : {12'(100 * k + 7), 12'(16 * k + 3)}, "R9 field write idle");
    step(1, 0, 0, 0, 0, 0, 0, "R2 frame loads field 0");
    step(1, 0, 0, 0, 0, 0, 0, "R3 length one repeats");

    // R4: program order 5,2,7 of length 3; no effect until frame
    cmd(2'd1, 3'd0, 24'd5, "R4 pending entry");
    cmd(2'd1, 3'd1, 24'd2, "R4 pending entry");
    cmd(2'd1, 3'd2, 24'd7, "R4 pending entry");
    cmd(2'd2, 3'd0, 24'd2, "R4 pending length");
    step(1, 0, 0, 0, 0, 0, 0, "R4 new list entry 0");
    step(0, 1, 0, 0, 0, 0, 0, "R6 first line keeps row");
    step(0, 1, 0, 0, 0, 0, 0, "R6 row wraps to 0");
    for (int k = 0; k < 9; k++) step(0, 0, 1, 0, 0, 0, 0, "R7 module step");
    cmd(2'd0, 3'd5, {12'd9, 12'd9}, "R9 mid-frame field write");
    step(0, 1, 0, 0, 0, 0, 0, "R9 line reload uses old base");
    step(1, 0, 0, 0, 0, 0, 0, "R3 second entry");
    step(1, 0, 0, 0, 0, 0, 0, "R3 third entry");
    step(1, 0, 0, 0, 0, 0, 0, "R3 wrap to entry 0");

    // R5: two swaps give one toggle
    cmd(2'd3, 3'd0, 24'd0, "R5 swap pending");
    cmd(2'd3, 3'd0, 24'd0, "R5 swap pending");
    step(1, 0, 0, 0, 0, 0, 0, "R5 buffer toggled");
    step(1, 0, 0, 0, 0, 0, 0, "R5 no second toggle");

    // R3: full length eight, reversed order
    for (int k = 0; k < 8; k++) cmd(2'd1, 3'(k), 24'(7 - k), "R4 pending entry");
    cmd(2'd2, 3'd0, 24'd7, "R4 pending length");
    for (int k = 0; k < 10; k++) step(1, 0, 0, 0, 0, 0, 0, "R3 length eight");

    // R8: all strobes together, then line+pixel
    step(1, 1, 1, 0, 0, 0, 0, "R8 frame wins");
    step(0, 1, 1, 0, 0, 0, 0, "R8 line wins");
    step(1, 0, 0, 1, 2'd2, 3'd0, 24'd0, "R4 command with frame");
    step(1, 0, 0, 0, 0, 0, 0, "R4 applies next frame");

    for (int n = 0; n < 4000; n++) begin
      bit f, l, p, cv;
      string tag;
      f  = ($urandom % 40) == 0;
      l  = ($urandom % 12) == 0;
      p  = ($urandom % 2) == 0;
      cv = ($urandom % 10) == 0;
      tag = f ? "R2 random frame" : (l ? "R6 random line" : (p ? "R7 random pixel" : "R8 random idle"));
      step(f, l, p, cv, 2'($urandom), 3'($urandom), 24'($urandom), tag);
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule